// File: doc/BRIEF.md
# Interrupt notification routing sequencer

This block carries one event notification from its target descriptor to a processor. A trigger names a descriptor by block and index and carries 31 bits of event data. The sequencer reads the descriptor, optionally pushes the data to a queue engine, and filters the event through a two-bit coalescing state (a "pending" bit P and a "queued" bit Q). It then reads the record of the target virtual processor and asks a presenter whether that processor is running on a thread. When no thread matches, the sequencer can note the event's priority in the record, so the event is replayed when the processor is dispatched again. The event can also escalate: the sequencer then restarts itself on a second descriptor that the first one names.

Descriptor storage, the virtual-processor records, the presenter and the queue engine are all outside the block. Each is reached through a simple port that answers in the same cycle. One stage of the sequence takes one clock cycle. A trigger is taken only while `trig_ready` is high, and each pass ends with a one-cycle `done`.

Top module: `nrs_route_seq`

## Requirements
- R1: After reset `trig_ready` is 1, and `err`, `done`, `enq_valid`, `pres_req`, `desc_wr_en` and `vp_wr_en` are 0. A trigger is accepted when `trig_valid` and `trig_ready` are both high. Every accepted trigger ends with exactly one one-cycle `done` pulse, and `trig_ready` is high again in the following cycle.
- R2: The descriptor vector on `desc_rd_data` holds these fields, from bit 74 down:
  - 8 flag bits, in this order: valid, enqueue, always-notify, backlog, escalate, unconditional-escalate, silent, format.
  - the notification PQ pair (2 bits), then the escalation PQ pair (2 bits). In each pair, P is the upper bit.
  - priority (8 bits).
  - virtual-processor block (4 bits), then virtual-processor index (8 bits).
  - escalation block (4 bits), then escalation index (8 bits).
  - escalation data (31 bits).
  If `desc_rd_ok` is low or the valid flag is clear, the pass ends. It then makes no enqueue, no descriptor write, no record write and no presenter request.
- R3: For a valid descriptor with the enqueue flag set, exactly one `enq_valid` pulse is issued for that pass. The pulse carries the data of the current trigger.
- R4: With the silent flag set, the notification stage is skipped: no notification PQ update and no presenter request. Processing goes straight to the escalation stage.
- R5: With format 0 and priority 0xFF, the descriptor is masked. The pass ends after any enqueue, and the presenter is never asked.
- R6: When the always-notify flag is clear, the notification pair is triggered as follows:
  - 00 becomes 10 and fires.
  - 10 becomes 11 and does not fire.
  - 11 and 01 are unchanged and do not fire.
  A changed pair is written back through `desc_wr_state`, laid out as {notification pair, escalation pair}. When the trigger does not fire, the pass ends.
- R7: The record on `vp_rd_data` holds a valid flag in bit 8 and a pending field in bits 7:0. An invalid record ends the pass. A valid record produces one presenter request, carrying the descriptor's format, virtual-processor block, virtual-processor index and priority. A presenter hit ends the pass.
- R8: On a presenter miss with the backlog flag set and format 0, the record's pending field is ORed with 0x80 >> priority and written back. The OR value is 0 for a priority above 7. A miss with backlog and format 1 is an invalid setting and ends the pass.
- R9: When the escalate flag is set, the escalation pair is triggered by the R6 rule, unless the unconditional flag is set. A changed escalation pair is written back. A firing trigger, or an unconditional one, restarts the sequence on the descriptor given by the escalation block and index, with the escalation data as the trigger data.
- R10: A pass may restart at most MAX_ESC_DEPTH times (default 4). A further restart is refused: `err` is set and the pass ends. `err` stays high until the next trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger request |
| trig_blk | input | 4 | Target descriptor block |
| trig_idx | input | 8 | Target descriptor index |
| trig_data | input | 31 | Event data |
| trig_ready | output | 1 | Sequencer idle, trigger can be taken |
| done | output | 1 | One-cycle end-of-pass pulse |
| err | output | 1 | Escalation depth exceeded in the last pass |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_blk | output | 4 | Descriptor block for read and write |
| desc_idx | output | 8 | Descriptor index for read and write |
| desc_rd_ok | input | 1 | Descriptor could be read |
| desc_rd_data | input | 75 | Descriptor contents |
| desc_wr_en | output | 1 | Write-back of the two PQ pairs |
| desc_wr_state | output | 4 | {notification pair, escalation pair} |
| enq_valid | output | 1 | Enqueue request |
| enq_data | output | 31 | Data to enqueue |
| vp_rd_en | output | 1 | Record read strobe |
| vp_blk | output | 4 | Virtual-processor block |
| vp_idx | output | 8 | Virtual-processor index |
| vp_rd_data | input | 9 | {valid, pending[7:0]} |
| vp_wr_en | output | 1 | Pending-field write-back |
| vp_wr_pend | output | 8 | New pending field |
| pres_req | output | 1 | Presenter match request |
| pres_fmt | output | 1 | Request format |
| pres_blk | output | 4 | Requested processor block |
| pres_idx | output | 8 | Requested processor index |
| pres_prio | output | 8 | Requested priority |
| pres_hit | input | 1 | Presenter found a dispatched match |

## Verification
A pass takes one cycle to accept the trigger and one cycle per stage. The stages are descriptor, notification coalescing, record with presenter, and escalation. `done` follows the last stage, so a pass can last anywhere from three cycles to several times that when escalation chains. For this reason the bench does not sample at fixed offsets. It records every port transaction at each clock edge, waits for the `done` pulse, and only then compares the enqueue count and data hash, the presenter request count, both PQ pairs of every descriptor, the pending field of every record, and `err` against a reference model. Two cycles later it checks that no second `done` has appeared and that `trig_ready` has returned.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    localparam int BLK_W  = 4;
    localparam int IDX_W  = 8;
    localparam int DATA_W = 31;
    localparam int PRIO_W = 8;
    localparam int PEND_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = {PRIO_W{1'b1}};

    typedef logic [1:0] pq_t;
    localparam pq_t PQ_IDLE = 2'b00;
    localparam pq_t PQ_PEND = 2'b10;
    localparam pq_t PQ_FULL = 2'b11;
    localparam pq_t PQ_OFF  = 2'b01;

    typedef struct packed {
        logic              valid;
        logic              enq_en;
        logic              ntf_always;
        logic              backlog;
        logic              esc_en;
        logic              uncond;
        logic              silent;
        logic              fmt;
        pq_t               ntf_pq;
        pq_t               esc_pq;
        logic [PRIO_W-1:0] prio;
        logic [BLK_W-1:0]  vp_blk;
        logic [IDX_W-1:0]  vp_idx;
        logic [BLK_W-1:0]  esc_blk;
        logic [IDX_W-1:0]  esc_idx;
        logic [DATA_W-1:0] esc_data;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
    localparam int REC_W  = PEND_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC, ST_NPQ, ST_VP, ST_ESC, ST_DONE
    } state_t;
endpackage

// File: rtl/nrs_pq_trigger.sv
module nrs_pq_trigger
    import nrs_pkg::*;
(
    input  pq_t  pq_in,
    output pq_t  pq_out,
    output logic fire
);
    always_comb begin
        case (pq_in)
            PQ_IDLE: begin pq_out = PQ_PEND; fire = 1'b1; end
            PQ_PEND: begin pq_out = PQ_FULL; fire = 1'b0; end
            default: begin pq_out = pq_in;   fire = 1'b0; end
        endcase
    end
endmodule

// File: rtl/nrs_pend_bit.sv
module nrs_pend_bit
    import nrs_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    output logic [PEND_W-1:0] pend
);
    for (genvar g = 0; g < PEND_W; g++) begin : g_bit
        assign pend[PEND_W-1-g] = (prio == PRIO_W'(g));
    end
endmodule

// File: rtl/nrs_depth_ctr.sv
module nrs_depth_ctr #(
    parameter int MAX_DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_DEPTH + 1);
    logic [CW-1:0] cnt;

    assign at_limit = (cnt == CW'(MAX_DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

    assert_no_step_past_limit_R10: assert property (@(posedge clk) disable iff (rst)
        step |-> !at_limit);
endmodule

// File: rtl/nrs_route_seq.sv
module nrs_route_seq
    import nrs_pkg::*;
#(
    parameter int MAX_ESC_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_valid,
    input  logic [BLK_W-1:0]  trig_blk,
    input  logic [IDX_W-1:0]  trig_idx,
    input  logic [DATA_W-1:0] trig_data,
    output logic              trig_ready,
    output logic              done,
    output logic              err,
    output logic              desc_rd_en,
    output logic [BLK_W-1:0]  desc_blk,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic              desc_rd_ok,
    input  logic [DESC_W-1:0] desc_rd_data,
    output logic              desc_wr_en,
    output logic [3:0]        desc_wr_state,
    output logic              enq_valid,
    output logic [DATA_W-1:0] enq_data,
    output logic              vp_rd_en,
    output logic [BLK_W-1:0]  vp_blk,
    output logic [IDX_W-1:0]  vp_idx,
    input  logic [REC_W-1:0]  vp_rd_data,
    output logic              vp_wr_en,
    output logic [PEND_W-1:0] vp_wr_pend,
    output logic              pres_req,
    output logic              pres_fmt,
    output logic [BLK_W-1:0]  pres_blk,
    output logic [IDX_W-1:0]  pres_idx,
    output logic [PRIO_W-1:0] pres_prio,
    input  logic              pres_hit
);
    state_t            st;
    state_t            after_desc;
    desc_t             d;
    desc_t             din;
    logic [BLK_W-1:0]  cur_blk;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] cur_data;
    pq_t               pq_src [2];
    pq_t               pq_new [2];
    logic [1:0]        pq_fire;
    logic [PEND_W-1:0] pend;
    logic              at_limit;
    logic              desc_good;
    logic              vp_ok;
    logic              esc_go;
    logic              accept;

    assign din       = desc_t'(desc_rd_data);
    assign desc_good = desc_rd_ok && din.valid;
    assign vp_ok     = vp_rd_data[PEND_W];
    assign accept    = (st == ST_IDLE) && trig_valid;

    // Coalescing units: index 0 filters notification, index 1 escalation
    assign pq_src[0] = d.ntf_pq;
    assign pq_src[1] = d.esc_pq;
    for (genvar g = 0; g < 2; g++) begin : g_pq
        nrs_pq_trigger u_pq (
            .pq_in  (pq_src[g]),
            .pq_out (pq_new[g]),
            .fire   (pq_fire[g])
        );
    end

    nrs_pend_bit u_pend (
        .prio (d.prio),
        .pend (pend)
    );

    assign esc_go = d.esc_en && (d.uncond || pq_fire[1]);

    nrs_depth_ctr #(.MAX_DEPTH(MAX_ESC_DEPTH)) u_depth (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     ((st == ST_ESC) && esc_go && !at_limit),
        .at_limit (at_limit)
    );

    // Route taken once a valid descriptor has been read
    always_comb begin
        if (din.silent)                             after_desc = ST_ESC;
        else if (!din.fmt && din.prio == PRIO_MASKED) after_desc = ST_DONE;
        else if (!din.ntf_always)                   after_desc = ST_NPQ;
        else                                        after_desc = ST_VP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            err      <= 1'b0;
            d        <= '0;
            cur_blk  <= '0;
            cur_idx  <= '0;
            cur_data <= '0;
        end else begin
            case (st)
                ST_IDLE: if (trig_valid) begin
                    cur_blk  <= trig_blk;
                    cur_idx  <= trig_idx;
                    cur_data <= trig_data;
                    err      <= 1'b0;
                    st       <= ST_DESC;
                end
                ST_DESC: begin
                    if (desc_good) begin
                        d  <= din;
                        st <= after_desc;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_NPQ: begin
                    d.ntf_pq <= pq_new[0];
                    st       <= pq_fire[0] ? ST_VP : ST_DONE;
                end
                ST_VP: begin
                    if (!vp_ok || pres_hit || (d.backlog && d.fmt)) st <= ST_DONE;
                    else                                             st <= ST_ESC;
                end
                ST_ESC: begin
                    if (d.esc_en && !d.uncond) d.esc_pq <= pq_new[1];
                    if (!esc_go) begin
                        st <= ST_DONE;
                    end else if (at_limit) begin
                        err <= 1'b1;
                        st  <= ST_DONE;
                    end else begin
                        cur_blk  <= d.esc_blk;
                        cur_idx  <= d.esc_idx;
                        cur_data <= d.esc_data;
                        st       <= ST_DESC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign trig_ready = (st == ST_IDLE);
    assign done       = (st == ST_DONE);

    assign desc_rd_en = (st == ST_DESC);
    assign desc_blk   = cur_blk;
    assign desc_idx   = cur_idx;
    assign enq_valid  = (st == ST_DESC) && desc_good && din.enq_en;
    assign enq_data   = cur_data;

    assign desc_wr_en = ((st == ST_NPQ) && (pq_new[0] != d.ntf_pq)) ||
                        ((st == ST_ESC) && d.esc_en && !d.uncond && (pq_new[1] != d.esc_pq));
    assign desc_wr_state = (st == ST_NPQ) ? {pq_new[0], d.esc_pq} : {d.ntf_pq, pq_new[1]};

    assign vp_rd_en   = (st == ST_VP);
    assign vp_blk     = d.vp_blk;
    assign vp_idx     = d.vp_idx;
    assign pres_req   = (st == ST_VP) && vp_ok;
    assign pres_fmt   = d.fmt;
    assign pres_blk   = d.vp_blk;
    assign pres_idx   = d.vp_idx;
    assign pres_prio  = d.prio;
    assign vp_wr_en   = pres_req && !pres_hit && d.backlog && !d.fmt;
    assign vp_wr_pend = vp_rd_data[PEND_W-1:0] | pend;

    assert_done_then_ready_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> trig_ready);
    assert_stages_hold_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NPQ || st == ST_VP || st == ST_ESC) |-> d.valid);
    assert_enq_from_flag_R3: assert property (@(posedge clk) disable iff (rst)
        enq_valid |=> (d.enq_en && !enq_valid));
    assert_silent_no_query_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VP) |-> !d.silent);
    assert_masked_no_query_R5: assert property (@(posedge clk) disable iff (rst)
        pres_req |-> !(pres_fmt == 1'b0 && pres_prio == PRIO_MASKED));
    assert_off_pair_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NPQ && d.ntf_pq == PQ_OFF && !d.ntf_always) |=> (st == ST_DONE));
    assert_one_query_R7: assert property (@(posedge clk) disable iff (rst)
        pres_req |=> !pres_req);
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);
endmodule

// File: tb/nrs_route_seq_test.sv
`timescale 1ns/1ps
module nrs_route_seq_test;
    import nrs_pkg::*;

    localparam int MAXD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              trig_valid = 1'b0;
    logic [BLK_W-1:0]  trig_blk = '0;
    logic [IDX_W-1:0]  trig_idx = '0;
    logic [DATA_W-1:0] trig_data = '0;
    logic trig_ready, done, err, desc_rd_en, desc_rd_ok, desc_wr_en, enq_valid;
    logic vp_rd_en, vp_wr_en, pres_req, pres_fmt, pres_hit;
    logic [BLK_W-1:0]  desc_blk, vp_blk, pres_blk;
    logic [IDX_W-1:0]  desc_idx, vp_idx, pres_idx;
    logic [DESC_W-1:0] desc_rd_data;
    logic [3:0]        desc_wr_state;
    logic [DATA_W-1:0] enq_data;
    logic [REC_W-1:0]  vp_rd_data;
    logic [PEND_W-1:0] vp_wr_pend;
    logic [PRIO_W-1:0] pres_prio;

    desc_t             desc_mem [16];
    logic [REC_W-1:0]  vp_mem   [16];
    desc_t             ld_desc  [16];
    logic [REC_W-1:0]  ld_vp    [16];
    desc_t             exp_desc [16];
    logic [REC_W-1:0]  exp_vp   [16];
    logic              hit_tbl  [16];
    logic              load_req = 1'b0;

    int          mon_enq = 0, mon_pres = 0, mon_done = 0;
    logic [31:0] mon_hash = '0;
    int          m_enq, m_pres;
    logic [31:0] m_hash;
    logic        m_err;
    int          checks = 0, errors = 0;

    nrs_route_seq #(.MAX_ESC_DEPTH(MAXD)) uut (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_blk(trig_blk),
        .trig_idx(trig_idx), .trig_data(trig_data), .trig_ready(trig_ready),
        .done(done), .err(err), .desc_rd_en(desc_rd_en), .desc_blk(desc_blk),
        .desc_idx(desc_idx), .desc_rd_ok(desc_rd_ok), .desc_rd_data(desc_rd_data),
        .desc_wr_en(desc_wr_en), .desc_wr_state(desc_wr_state), .enq_valid(enq_valid),
        .enq_data(enq_data), .vp_rd_en(vp_rd_en), .vp_blk(vp_blk), .vp_idx(vp_idx),
        .vp_rd_data(vp_rd_data), .vp_wr_en(vp_wr_en), .vp_wr_pend(vp_wr_pend),
        .pres_req(pres_req), .pres_fmt(pres_fmt), .pres_blk(pres_blk),
        .pres_idx(pres_idx), .pres_prio(pres_prio), .pres_hit(pres_hit)
    );

    // External tables and presenter, answering in the same cycle
    assign desc_rd_ok   = (desc_blk == '0);
    assign desc_rd_data = desc_mem[desc_idx[3:0]];
    assign vp_rd_data   = (vp_blk == '0) ? vp_mem[vp_idx[3:0]] : '0;
    assign pres_hit     = pres_req && (pres_blk == '0) && hit_tbl[pres_idx[3:0]];

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < 16; i++) begin
                desc_mem[i] <= ld_desc[i];
                vp_mem[i]   <= ld_vp[i];
            end
        end else if (!rst) begin
            if (desc_wr_en) begin
                desc_mem[desc_idx[3:0]].ntf_pq <= desc_wr_state[3:2];
                desc_mem[desc_idx[3:0]].esc_pq <= desc_wr_state[1:0];
            end
            if (vp_wr_en) vp_mem[vp_idx[3:0]][PEND_W-1:0] <= vp_wr_pend;
            if (enq_valid) begin
                mon_enq  <= mon_enq + 1;
                mon_hash <= {mon_hash[30:0], mon_hash[31]} ^ {1'b0, enq_data};
            end
            if (pres_req) mon_pres <= mon_pres + 1;
            if (done)     mon_done <= mon_done + 1;
        end
    end

    function automatic logic [2:0] pq_step(input pq_t p);
        case (p)
            2'b00:   return {2'b10, 1'b1};
            2'b10:   return {2'b11, 1'b0};
            default: return {p, 1'b0};
        endcase
    endfunction

    function automatic logic [7:0] pend_of(input logic [7:0] pr);
        return (pr < 8) ? (8'h80 >> pr) : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_run(input logic [3:0] b0, input logic [7:0] i0, input logic [30:0] dt0);
        logic [3:0]  b  = b0;
        logic [7:0]  ix = i0;
        logic [30:0] dt = dt0;
        int          depth = 0;
        desc_t       dd;
        logic [8:0]  rec;
        logic [2:0]  r;
        m_enq = 0; m_pres = 0; m_hash = '0; m_err = 1'b0;
        while (1) begin
            if (b != 0) break;
            dd = exp_desc[ix[3:0]];
            if (!dd.valid) break;
            if (dd.enq_en) begin
                m_enq++;
                m_hash = {m_hash[30:0], m_hash[31]} ^ {1'b0, dt};
            end
            if (!dd.silent) begin
                if (!dd.fmt && dd.prio == 8'hFF) break;
                if (!dd.ntf_always) begin
                    r = pq_step(dd.ntf_pq);
                    dd.ntf_pq = r[2:1];
                    exp_desc[ix[3:0]].ntf_pq = r[2:1];
                    if (!r[0]) break;
                end
                rec = (dd.vp_blk == 0) ? exp_vp[dd.vp_idx[3:0]] : 9'h0;
                if (!rec[8]) break;
                m_pres++;
                if (dd.vp_blk == 0 && hit_tbl[dd.vp_idx[3:0]]) break;
                if (dd.backlog) begin
                    if (dd.fmt) break;
                    exp_vp[dd.vp_idx[3:0]][7:0] = rec[7:0] | pend_of(dd.prio);
                end
            end
            if (!dd.esc_en) break;
            if (!dd.uncond) begin
                r = pq_step(dd.esc_pq);
                exp_desc[ix[3:0]].esc_pq = r[2:1];
                if (!r[0]) break;
            end
            if (depth == MAXD) begin m_err = 1'b1; break; end
            depth++;
            b = dd.esc_blk; ix = dd.esc_idx; dt = dd.esc_data;
        end
    endtask

    task automatic load_tables();
        for (int i = 0; i < 16; i++) begin
            exp_desc[i] = ld_desc[i];
            exp_vp[i]   = ld_vp[i];
        end
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [3:0] b, input logic [7:0] ix,
                            input logic [30:0] dt);
        int e0 = mon_enq, p0 = mon_pres, d0 = mon_done, wd = 0;
        logic [63:0] st_a, st_e;
        int vp_bad = 0;
        model_run(b, ix, dt);
        @(negedge clk);
        trig_valid = 1'b1; trig_blk = b; trig_idx = ix; trig_data = dt;
        @(negedge clk);
        trig_valid = 1'b0;
        while (mon_done == d0 && wd < 500) begin @(negedge clk); wd++; end
        if (wd >= 500) chk(1'b0, tag, "R1 watchdog no done", 0, 1);
        @(negedge clk); @(negedge clk);
        chk(mon_done == d0 + 1, tag, "R1 done pulses", mon_done - d0, 1);
        chk(trig_ready == 1'b1, tag, "R1 ready after done", trig_ready, 1);
        chk(mon_enq - e0 == m_enq, tag, "R3 enqueue count", mon_enq - e0, m_enq);
        chk(mon_hash == m_hash, tag, "R3 enqueue data hash", mon_hash, m_hash);
        mon_hash = '0;
        chk(mon_pres - p0 == m_pres, tag, "R7 presenter requests", mon_pres - p0, m_pres);
        for (int i = 0; i < 16; i++) begin
            st_a[i*4 +: 4] = {desc_mem[i].ntf_pq, desc_mem[i].esc_pq};
            st_e[i*4 +: 4] = {exp_desc[i].ntf_pq, exp_desc[i].esc_pq};
            if (vp_mem[i] != exp_vp[i]) vp_bad++;
        end
        chk(st_a == st_e, tag, "R6 R9 PQ pairs", st_a, st_e);
        chk(vp_bad == 0, tag, "R8 record mismatches", vp_bad, 0);
        chk(err == m_err, tag, "R10 err flag", err, m_err);
    endtask

    function automatic desc_t blank_desc();
        desc_t x = '0;
        x.valid = 1'b1; x.ntf_always = 1'b1; x.prio = 8'd2; x.vp_idx = 8'd1;
        return x;
    endfunction

    function automatic desc_t rand_desc();
        desc_t x;
        logic [31:0] r = $urandom;
        x.valid = (r[3:0] != 0); x.enq_en = r[4]; x.ntf_always = r[5];
        x.backlog = r[6]; x.esc_en = r[7]; x.uncond = r[8] & r[9];
        x.silent = (r[12:10] == 0); x.fmt = (r[14:13] == 0);
        x.ntf_pq = r[16:15]; x.esc_pq = r[18:17];
        x.prio = (r[21:19] == 0) ? 8'hFF : 8'($urandom % 9);
        x.vp_blk = (r[24:22] == 0) ? 4'd1 : 4'd0; x.vp_idx = 8'($urandom % 16);
        x.esc_blk = (r[27:25] == 0) ? 4'd2 : 4'd0; x.esc_idx = 8'($urandom % 16);
        x.esc_data = 31'($urandom);
        return x;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1 global watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) begin
            ld_desc[i] = '0; ld_vp[i] = '0; hit_tbl[i] = 1'b0;
        end
        ld_vp[1] = 9'h100;
        load_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(trig_ready && !err && !done && !enq_valid && !pres_req && !desc_wr_en && !vp_wr_en,
            "R1", "reset outputs", {trig_ready, err, done, enq_valid, pres_req}, 5'b10000);

        // R2 invalid and unreadable descriptors
        ld_desc[0] = blank_desc(); ld_desc[0].valid = 1'b0; ld_desc[0].enq_en = 1'b1;
        load_tables();
        run_case("R2 invalid", 4'd0, 8'd0, 31'h11);
        chk(mon_enq == 0, "R2", "no enqueue on invalid", mon_enq, 0);
        run_case("R2 unreadable", 4'd3, 8'd0, 31'h12);

        // R3 R5 enqueue then masked
        ld_desc[2] = blank_desc(); ld_desc[2].enq_en = 1'b1; ld_desc[2].prio = 8'hFF;
        load_tables();
        run_case("R3 R5 masked enqueue", 4'd0, 8'd2, 31'h2345);
        chk(m_pres == 0 && m_enq == 1, "R5", "masked model counts", m_pres, 0);

        // R4 silent with unconditional escalation to invalid target
        ld_desc[3] = blank_desc(); ld_desc[3].silent = 1'b1; ld_desc[3].ntf_always = 1'b0;
        ld_desc[3].esc_en = 1'b1; ld_desc[3].uncond = 1'b1; ld_desc[3].esc_idx = 8'd0;
        load_tables();
        run_case("R4 silent", 4'd0, 8'd3, 31'h33);
        chk(desc_mem[3].ntf_pq == 2'b00, "R4", "notify pair untouched", desc_mem[3].ntf_pq, 0);

        // R6 trigger sequence 00 -> 10 -> 11, then 01 stays
        ld_desc[4] = blank_desc(); ld_desc[4].ntf_always = 1'b0; hit_tbl[1] = 1'b1;
        load_tables();
        run_case("R6 first", 4'd0, 8'd4, 31'h1);
        chk(desc_mem[4].ntf_pq == 2'b10, "R6", "pair after first", desc_mem[4].ntf_pq, 2'b10);
        run_case("R6 second", 4'd0, 8'd4, 31'h2);
        chk(desc_mem[4].ntf_pq == 2'b11, "R6", "pair after second", desc_mem[4].ntf_pq, 2'b11);
        ld_desc[4].ntf_pq = 2'b01;
        load_tables();
        run_case("R6 off", 4'd0, 8'd4, 31'h3);
        chk(desc_mem[4].ntf_pq == 2'b01, "R6", "off pair held", desc_mem[4].ntf_pq, 2'b01);

        // R7 invalid record, then hit suppresses backlog
        ld_desc[5] = blank_desc(); ld_desc[5].vp_idx = 8'd6; ld_desc[5].backlog = 1'b1;
        ld_desc[6] = blank_desc(); ld_desc[6].backlog = 1'b1;
        load_tables();
        run_case("R7 invalid record", 4'd0, 8'd5, 31'h5);
        run_case("R7 hit", 4'd0, 8'd6, 31'h6);

        // R8 miss with backlog: priority 3 sets 0x10; format 1 stops escalation
        hit_tbl[1] = 1'b0;
        ld_desc[7] = blank_desc(); ld_desc[7].backlog = 1'b1; ld_desc[7].prio = 8'd3;
        ld_desc[8] = blank_desc(); ld_desc[8].backlog = 1'b1; ld_desc[8].fmt = 1'b1;
        ld_desc[8].esc_en = 1'b1; ld_desc[8].uncond = 1'b1; ld_desc[8].esc_idx = 8'd2;
        ld_desc[2].enq_en = 1'b1;
        load_tables();
        run_case("R8 backlog", 4'd0, 8'd7, 31'h7);
        chk(vp_mem[1] == 9'h110, "R8", "pending field", vp_mem[1], 9'h110);
        run_case("R8 format 1", 4'd0, 8'd8, 31'h8);

        // R9 escalation chain through the escalation pair to an enqueuing target
        ld_desc[9] = blank_desc(); ld_desc[9].silent = 1'b1; ld_desc[9].esc_en = 1'b1;
        ld_desc[9].esc_idx = 8'd2; ld_desc[9].esc_data = 31'h7ABC;
        load_tables();
        run_case("R9 escalate", 4'd0, 8'd9, 31'h9);
        chk(m_enq == 1 && desc_mem[9].esc_pq == 2'b10, "R9", "escalation taken",
            desc_mem[9].esc_pq, 2'b10);
        run_case("R9 coalesced", 4'd0, 8'd9, 31'h9);

        // R10 self-loop beyond the depth limit
        ld_desc[10] = blank_desc(); ld_desc[10].silent = 1'b1; ld_desc[10].enq_en = 1'b1;
        ld_desc[10].esc_en = 1'b1; ld_desc[10].uncond = 1'b1; ld_desc[10].esc_idx = 8'd10;
        load_tables();
        run_case("R10 depth", 4'd0, 8'd10, 31'hA);
        chk(err == 1'b1 && m_enq == MAXD + 1, "R10", "err after limit", err, 1);
        run_case("R10 clear", 4'd0, 8'd2, 31'hB);
        chk(err == 1'b0, "R10", "err cleared by new trigger", err, 0);

        // Random tables and triggers, all requirements R1 to R10 by model
        for (int n = 0; n < 300; n++) begin
            if (n % 10 == 0) begin
                for (int i = 0; i < 16; i++) begin
                    ld_desc[i] = rand_desc();
                    ld_vp[i]   = {($urandom % 5) != 0, 8'($urandom)};
                    hit_tbl[i] = ($urandom % 3) == 0;
                end
                load_tables();
            end
            run_case("random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10",
                     (($urandom % 12) == 0) ? 4'd1 : 4'd0, 8'($urandom % 16), 31'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule